// File: doc/BRIEF.md
# Link Built-In Self-Test Pattern Sequencer

This block drives a self-test bit stream onto a serial link of up to 14 lanes and checks the returning lanes against the same stream. The stream is built from 12-bit frames taken from three sources in turn: a stored 24-bit pattern, a modulo-N counter and a fixed constant. A 3-bit order code picks which of the six orderings of these sources is used. Each source stays active for a programmed number of frames before the next one takes over. After the third source the sequence returns to the first, and it keeps running as long as the enable input is held high.

Each frame goes out least significant bit first, one bit per clock (one unit interval). The bit is copied to every lane that the transmit mask enables, and masked lanes drive 0. The receive side builds the expected bit locally in the same cycle. A lane enabled by the receive mask that disagrees with it raises a sticky error flag. Software writes the configuration through a simple address/data write port. A test starts on the first cycle the enable is seen high while the sequencer is idle. Starting a test clears all error flags and restarts the sequence.

Configuration word addresses: 0 order code (data bits 2:0), 1 stored pattern (bits 23:0), 2 transmit mask (bits 13:0), 3 receive mask (bits 13:0), 4 counter modulus N (bits 11:0, reset 16), 5 constant (bits 11:0, reset 0), 6 frames per source (bits 7:0, reset 1).

Top module: `link_selftest_seq`

## Requirements
- R1: Order codes select the source sequence. The sources are P = stored pattern, C = counter and K = constant. Code 0 gives P,C,K; 1 gives P,K,C; 2 gives C,P,K; 3 gives C,K,P; 4 gives K,P,C; 5 gives K,C,P.
- R2: Order codes 6 and 7 give the same stream as code 0.
- R3: The stored-pattern source alternates its two halves on successive pattern frames, starting with bits 11:0 and then bits 23:12. The half toggles on every pattern frame across source visits, and restarts at the low half when a test starts.
- R4: After reset, the stored pattern is 0x02CCFD, the order code is 0 and each source runs for 1 frame.
- R5: Every frame lasts 12 clocks and is sent least significant bit first. Bit 0 appears in the cycle after the start edge, and the same bit goes to every enabled transmit lane.
- R6: The transmit mask resets to 0x3FFF. A lane whose mask bit is 0 drives 0, and the transmit mask has no effect on error flagging.
- R7: The receive mask resets to 0x3FFF. A lane whose receive mask bit is 0 never sets its error flag, and the receive mask has no effect on transmitted lanes.
- R8: The counter source emits 0 in its first frame after a start. It adds 1 for each counter frame and wraps to 0 after N-1; an N of 0 or 1 always gives 0.
- R9: The constant source emits the programmed 12-bit constant in every constant frame.
- R10: Each source lasts the programmed number of frames, with 0 treated as 1. After the third source, the sequence returns to the first.
- R11: A lane's error flag is set by a mismatch while the test is active. The flag stays set through idle periods and is cleared only in the cycle a new test starts.
- R12: After reset, and whenever the enable is low, all transmit lanes are 0. All error flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration word address |
| cfgData | input | 24 | Configuration write data |
| testEn | input | 1 | Test enable; a rising level starts a test |
| rxLane | input | 14 | Received lane bits |
| txLane | output | 14 | Transmitted lane bits |
| laneErr | output | 14 | Sticky per-lane mismatch flags |

## Verification
The bench uses the default 14 lanes and 12-bit frames. It shrinks the runtime settings to a modulus of 3 and two frames per source. With those settings, a run of a few dozen frames covers every source visit, the counter wrap, both pattern halves across separate visits and the return to the first source, for all six order codes and both reserved codes. Masks are set to sparse values so that gated transmit lanes and unchecked receive lanes can be told apart on the ports. Errors are injected on all lanes to show that only receive-enabled lanes flag.

// File: rtl/lst_pkg.sv
package lst_pkg;
  localparam int FRAME_W   = 12;
  localparam int BIT_IDX_W = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    SRC_PAT = 2'd0,
    SRC_CNT = 2'd1,
    SRC_CON = 2'd2
  } src_e;

  typedef struct packed {
    logic                 start;
    logic                 active;
    logic                 frameEnd;
    src_e                 src;
    logic [BIT_IDX_W-1:0] bitSel;
  } seq_strobe_t;

  function automatic src_e srcOf(input logic [2:0] order, input logic [1:0] stage);
    src_e s0, s1, s2;
    case (order)
      3'd1:    begin s0 = SRC_PAT; s1 = SRC_CON; s2 = SRC_CNT; end
      3'd2:    begin s0 = SRC_CNT; s1 = SRC_PAT; s2 = SRC_CON; end
      3'd3:    begin s0 = SRC_CNT; s1 = SRC_CON; s2 = SRC_PAT; end
      3'd4:    begin s0 = SRC_CON; s1 = SRC_PAT; s2 = SRC_CNT; end
      3'd5:    begin s0 = SRC_CON; s1 = SRC_CNT; s2 = SRC_PAT; end
      default: begin s0 = SRC_PAT; s1 = SRC_CNT; s2 = SRC_CON; end
    endcase
    case (stage)
      2'd0:    return s0;
      2'd1:    return s1;
      default: return s2;
    endcase
  endfunction
endpackage

// File: rtl/lst_ctrl.sv
module lst_ctrl
  import lst_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testEn,
  input  logic [2:0]       cfgOrder,
  input  logic [LEN_W-1:0] cfgLen,
  output seq_strobe_t      strb
);
  logic                 running;
  logic [1:0]           stage;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [LEN_W-1:0]     frameIdx;
  logic [LEN_W-1:0]     lenEff;
  logic                 lastBit, lastFrame, start, active;

  assign lenEff    = (cfgLen == '0) ? LEN_W'(1) : cfgLen;
  assign lastBit   = (bitIdx == BIT_IDX_W'(FRAME_W - 1));
  assign lastFrame = (frameIdx == lenEff - LEN_W'(1));
  assign start     = testEn && !running;
  assign active    = testEn && running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      stage    <= 2'd0;
      bitIdx   <= '0;
      frameIdx <= '0;
    end else if (start) begin
      running  <= 1'b1;
      stage    <= 2'd0;
      bitIdx   <= '0;
      frameIdx <= '0;
    end else if (!testEn) begin
      running <= 1'b0;
    end else if (running) begin
      if (lastBit) begin
        bitIdx <= '0;
        if (lastFrame) begin
          frameIdx <= '0;
          stage    <= (stage == 2'd2) ? 2'd0 : stage + 2'd1;
        end else begin
          frameIdx <= frameIdx + LEN_W'(1);
        end
      end else begin
        bitIdx <= bitIdx + BIT_IDX_W'(1);
      end
    end
  end

  always_comb begin
    strb.start    = start;
    strb.active   = active;
    strb.frameEnd = active && lastBit;
    strb.src      = srcOf(cfgOrder, stage);
    strb.bitSel   = bitIdx;
  end

  // R5
  bit_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitIdx < BIT_IDX_W'(FRAME_W)));

  // R10
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !lastBit) |=> $stable(stage));

  // R10
  stage_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && lastBit && lastFrame) |=> (stage != $past(stage)));
endmodule

// File: rtl/lst_dpath.sv
module lst_dpath
  import lst_pkg::*;
#(
  parameter int LANES  = 14,
  parameter int DATA_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  seq_strobe_t       strb,
  input  logic [LANES-1:0]  rxLane,
  output logic [LANES-1:0]  txLane,
  output logic [LANES-1:0]  laneErr,
  output logic [2:0]        cfgOrder,
  output logic [LEN_W-1:0]  cfgLen
);
  localparam int PAT_W = 2 * FRAME_W;

  logic [PAT_W-1:0]   patReg;
  logic [LANES-1:0]   txMask, rxMask;
  logic [FRAME_W-1:0] modN, constVal, cntVal, cntNext, frameWord;
  logic               patHalf, expBit;
  logic [LANES-1:0]   expLanes, missLanes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgOrder <= 3'd0;
      patReg   <= PAT_W'(24'h02CCFD);
      txMask   <= '1;
      rxMask   <= '1;
      modN     <= FRAME_W'(16);
      constVal <= '0;
      cfgLen   <= LEN_W'(1);
    end else if (cfgWe) begin
      case (cfgAddr)
        3'd0: cfgOrder <= cfgData[2:0];
        3'd1: patReg   <= cfgData[PAT_W-1:0];
        3'd2: txMask   <= cfgData[LANES-1:0];
        3'd3: rxMask   <= cfgData[LANES-1:0];
        3'd4: modN     <= cfgData[FRAME_W-1:0];
        3'd5: constVal <= cfgData[FRAME_W-1:0];
        3'd6: cfgLen   <= cfgData[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  assign cntNext = ((cntVal + FRAME_W'(1)) >= modN) ? '0 : cntVal + FRAME_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= '0;
      patHalf <= 1'b0;
    end else if (strb.start) begin
      cntVal  <= '0;
      patHalf <= 1'b0;
    end else if (strb.frameEnd) begin
      if (strb.src == SRC_CNT) cntVal <= cntNext;
      if (strb.src == SRC_PAT) patHalf <= !patHalf;
    end
  end

  always_comb begin
    case (strb.src)
      SRC_PAT: frameWord = patHalf ? patReg[PAT_W-1:FRAME_W] : patReg[FRAME_W-1:0];
      SRC_CNT: frameWord = cntVal;
      default: frameWord = constVal;
    endcase
  end

  assign expBit    = frameWord[strb.bitSel];
  assign expLanes  = {LANES{expBit}};
  assign txLane    = strb.active ? (expLanes & txMask) : '0;
  assign missLanes = (rxLane ^ expLanes) & rxMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             laneErr <= '0;
    else if (strb.start)   laneErr <= '0;
    else if (strb.active)  laneErr <= laneErr | missLanes;
  end

  // R12
  idle_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> (txLane == '0));

  // R6
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((txLane & ~txMask) == '0));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.frameEnd && strb.src == SRC_CNT) |->
      (cntVal == '0 || cntVal == $past(cntVal) + FRAME_W'(1)));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.start |=> ((laneErr & $past(laneErr)) == $past(laneErr)));

  // R7
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((laneErr & ~$past(laneErr) & ~$past(rxMask)) == '0));
endmodule

// File: rtl/link_selftest_seq.sv
module link_selftest_seq
  import lst_pkg::*;
#(
  parameter int LANES  = 14,
  parameter int DATA_W = 24,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              testEn,
  input  logic [LANES-1:0]  rxLane,
  output logic [LANES-1:0]  txLane,
  output logic [LANES-1:0]  laneErr
);
  seq_strobe_t      strb;
  logic [2:0]       cfgOrder;
  logic [LEN_W-1:0] cfgLen;

  lst_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .testEn(testEn),
    .cfgOrder(cfgOrder), .cfgLen(cfgLen), .strb(strb)
  );

  lst_dpath #(.LANES(LANES), .DATA_W(DATA_W), .LEN_W(LEN_W)) dpath_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strb(strb), .rxLane(rxLane), .txLane(txLane), .laneErr(laneErr),
    .cfgOrder(cfgOrder), .cfgLen(cfgLen)
  );
endmodule

// File: tb/link_selftest_seq_tb_top.sv
module link_selftest_seq_tb_top;
  localparam int LANES = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [2:0]        cfgAddr = '0;
  logic [23:0]       cfgData = '0;
  logic              testEn = 1'b0;
  logic [LANES-1:0]  rxLane = '0;
  logic [LANES-1:0]  txLane, laneErr;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  int         mOrder = 0;
  logic [23:0] mPat = 24'h02CCFD;
  int         mMod = 16;
  int         mConst = 0;
  int         mLen = 1;
  bit         expQ[$];

  always #4 clk = !clk;

  link_selftest_seq dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .testEn(testEn), .rxLane(rxLane), .txLane(txLane), .laneErr(laneErr)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wrCfg(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  function automatic int srcAt(input int order, input int stage);
    int tbl [6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
    int o = (order > 5) ? 0 : order;
    return tbl[o][stage];
  endfunction

  // driver side: fill the scoreboard queue with expected bits
  task automatic pushExpected(input int nFrames);
    int stage = 0, fin = 0, cnt = 0, half = 0;
    int len = (mLen == 0) ? 1 : mLen;
    logic [11:0] w;
    expQ.delete();
    for (int f = 0; f < nFrames; f++) begin
      case (srcAt(mOrder, stage))
        0: begin w = half ? mPat[23:12] : mPat[11:0]; half = 1 - half; end
        1: begin w = 12'(cnt); cnt = (cnt + 1 >= mMod) ? 0 : cnt + 1; end
        default: w = 12'(mConst);
      endcase
      for (int b = 0; b < 12; b++) expQ.push_back(w[b]);
      fin++;
      if (fin >= len) begin fin = 0; stage = (stage + 1) % 3; end
    end
  endtask

  // monitor side: pop and compare each unit interval, then check error flags
  task automatic runTest(input string tag, input int nFrames, input logic [13:0] txm,
                         input logic [13:0] inj, input logic [13:0] errExp);
    int bad = 0;
    bit e;
    logic [13:0] want;
    pushExpected(nFrames);
    @(negedge clk);
    testEn = 1'b1;
    @(posedge clk);
    while (expQ.size() > 0) begin
      @(negedge clk);
      e = expQ.pop_front();
      want = {14{e}} & txm;
      rxLane = {14{e}} ^ inj;
      if (txLane !== want) begin
        bad++;
        if (bad < 4) $display("FAIL %s tx got %h expected %h", tag, txLane, want);
      end
    end
    checks++;
    if (bad != 0) errs++;
    @(negedge clk);
    testEn = 1'b0;
    rxLane = '0;
    chk({tag, " err flags"}, 32'(laneErr), 32'(errExp));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 tx after reset", 32'(txLane), 0);
    chk("R12 err after reset", 32'(laneErr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 tx idle", 32'(txLane), 0);

    // R4 R5 R3 default settings: pattern 0x02CCFD, order 0, one frame per source
    runTest("R4 default run", 7, 14'h3FFF, 14'h0, 14'h0);

    // R1 R8 R9 R3 all six orders with modulus 3, two frames per source
    wrCfg(3'd1, 24'hABC123); mPat = 24'hABC123;
    wrCfg(3'd4, 24'd3);      mMod = 3;
    wrCfg(3'd5, 24'h000A5C); mConst = 12'hA5C;
    wrCfg(3'd6, 24'd2);      mLen = 2;
    for (int o = 0; o < 6; o++) begin
      wrCfg(3'd0, 24'(o)); mOrder = o;
      runTest($sformatf("R1 order %0d", o), 20, 14'h3FFF, 14'h0, 14'h0);
    end
    // R8 longer run covering repeated counter wrap
    wrCfg(3'd0, 24'd2); mOrder = 2;
    runTest("R8 counter wrap", 30, 14'h3FFF, 14'h0, 14'h0);
    // R9 other constant
    wrCfg(3'd5, 24'h000FFF); mConst = 12'hFFF;
    runTest("R9 constant", 12, 14'h3FFF, 14'h0, 14'h0);

    // R2 reserved codes
    wrCfg(3'd0, 24'd6); mOrder = 6;
    runTest("R2 code 6", 12, 14'h3FFF, 14'h0, 14'h0);
    wrCfg(3'd0, 24'd7); mOrder = 7;
    runTest("R2 code 7", 12, 14'h3FFF, 14'h0, 14'h0);

    // R10 zero length treated as one
    wrCfg(3'd0, 24'd5); mOrder = 5;
    wrCfg(3'd6, 24'd0); mLen = 0;
    runTest("R10 len zero", 9, 14'h3FFF, 14'h0, 14'h0);
    wrCfg(3'd6, 24'd3); mLen = 3;
    runTest("R10 len three", 12, 14'h3FFF, 14'h0, 14'h0);

    // R6 sparse tx mask, checking still sees all lanes matching
    wrCfg(3'd2, 24'h000055);
    runTest("R6 tx mask", 6, 14'h0055, 14'h0, 14'h0);
    wrCfg(3'd2, 24'h003FFF);

    // R7 rx mask limits flags; tx unaffected
    wrCfg(3'd3, 24'h0000F0);
    runTest("R7 rx mask", 3, 14'h3FFF, 14'h3FFF, 14'h00F0);

    // R11 sticky through idle, cleared at new start
    repeat (5) @(negedge clk);
    chk("R11 err held idle", 32'(laneErr), 32'h00F0);
    chk("R12 tx idle after run", 32'(txLane), 0);
    @(negedge clk);
    testEn = 1'b1;
    @(negedge clk);
    chk("R11 err cleared on start", 32'(laneErr), 0);
    testEn = 1'b0;
    @(negedge clk);
    wrCfg(3'd3, 24'h003FFF);
    runTest("R11 single lane error", 2, 14'h3FFF, 14'h0200, 14'h0200);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule